// File: doc/BRIEF.md
# Edge Capture Unit with Spike Filter

This block takes a snapshot of a free-running counter value when a chosen transition appears on an external trigger. The trigger comes from one of two inputs: a dedicated capture pin or the output of an analog comparator. A select input picks which one is used. The chosen trigger first passes through a two-stage synchronizer. It then goes through an optional digital filter that ignores pulses shorter than four clock cycles. Last, an edge detector fires on either a rising or a falling transition, as set by a polarity input.

On a detected edge, the unit copies the counter value into its capture register and raises a sticky capture flag. The flag stays high until the flag-clear input is pulsed. A later capture overwrites the register even while the flag is still set.

When the counter uses the capture register as its TOP limit, the `top_mode` input is held high. In that mode, trigger edges are ignored and the register can be loaded through a write port.

Top module: `edge_capture_unit`

## Requirements
- R1: After synchronous reset, `cap_value` is 0 and `cap_flag` is 0. The internal trigger level also resets low.
- R2: With the filter off, a trigger change driven just after clock edge k is captured at edge k+3. `cap_value` then holds the `count_in` value that was present during the cycle just before edge k+3.
- R3: With the filter on, the same capture happens at edge k+7, which is four cycles later than in R2. It stores the `count_in` value present just before edge k+7.
- R4: With the filter on, a trigger pulse lasting three cycles or less produces no capture. A pulse of four cycles is captured.
- R5: `edge_rise`=1 captures on a 0-to-1 trigger transition and `edge_rise`=0 captures on a 1-to-0 transition. The opposite transition leaves `cap_value` and `cap_flag` unchanged.
- R6: `src_sel`=0 selects `trig_pin` and `src_sel`=1 selects `trig_cmp`. Transitions on the unselected source have no effect.
- R7: `cap_flag` goes to 1 at the clock edge that captures and holds until `flag_clr`=1 is sampled. It reads 0 at the edge after that clear, as long as no capture happens in the same cycle.
- R8: When a capture and `flag_clr`=1 fall on the same clock edge, `cap_flag` is 1 afterwards.
- R9: A capture while `cap_flag` is already 1 still replaces `cap_value` with the new count, and the flag stays 1.
- R10: While `top_mode`=1, trigger edges neither change `cap_value` nor set `cap_flag`. A cycle with `wr_en`=1 loads `wr_data` into `cap_value` at the next edge.
- R11: While `top_mode`=0, `wr_en` has no effect on `cap_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_pin | input | 1 | Dedicated capture pin trigger |
| trig_cmp | input | 1 | Analog comparator trigger |
| src_sel | input | 1 | 0: pin, 1: comparator |
| edge_rise | input | 1 | 1: rising edge, 0: falling edge |
| filt_en | input | 1 | Enables the four-sample spike filter |
| top_mode | input | 1 | Register serves as TOP: write enabled, capture disabled |
| count_in | input | 16 | Live counter value |
| wr_en | input | 1 | Write strobe, honoured only in TOP mode |
| wr_data | input | 16 | Write data |
| flag_clr | input | 1 | Clears the capture flag when 1 |
| cap_value | output | 16 | Captured or written register value |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
Two of the block's functions can fall in the same cycle: setting the flag on a capture and clearing it through `flag_clr`. The bench times a trigger change so that its capture edge is known three cycles ahead. It then raises `flag_clr` for exactly the cycle that ends at that capture edge. The result is judged by the scoreboard entry for that capture: it requires the new count in `cap_value` and `cap_flag` still high. A second overlap is also checked, where a capture arrives while the flag is still set; the new value must replace the old one.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

    typedef enum logic {
        SRC_PIN = 1'b0,
        SRC_CMP = 1'b1
    } ecap_src_e;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } ecap_edge_e;

    // set dominates clear
    function automatic logic ecap_flag_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/ecap_sync.sv
module ecap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= (chain_q << 1) | STAGES'(din);
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ecap_filter.sv
module ecap_filter #(
    parameter int WINDOW = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic level
);
    localparam int HW = WINDOW - 1;

    logic filt_q;

    generate
        if (WINDOW > 1) begin : g_win
            logic [HW-1:0] hist_q;
            logic [WINDOW-1:0] win;
            assign win = {hist_q, din};
            always_ff @(posedge clk) begin
                if (rst) begin
                    hist_q <= '0;
                    filt_q <= 1'b0;
                end else begin
                    hist_q <= (hist_q << 1) | HW'(din);
                    if (&win)       filt_q <= 1'b1;
                    else if (~|win) filt_q <= 1'b0;
                end
            end
        end else begin : g_pass
            always_ff @(posedge clk) begin
                if (rst) filt_q <= 1'b0;
                else     filt_q <= din;
            end
        end
    endgenerate

    assign level = en ? filt_q : din;
endmodule

// File: rtl/ecap_edge.sv
module ecap_edge
    import ecap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       level,
    input  ecap_edge_e pol,
    output logic       evt
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    always_comb begin
        unique case (pol)
            EDGE_RISE: evt = level & ~prev_q;
            EDGE_FALL: evt = ~level & prev_q;
            default:   evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import ecap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_pin,
    input  logic             trig_cmp,
    input  logic             src_sel,
    input  logic             edge_rise,
    input  logic             filt_en,
    input  logic             top_mode,
    input  logic [CNT_W-1:0] count_in,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_flag
);
    ecap_src_e  src;
    ecap_edge_e pol;
    logic       raw_trig;
    logic       sync_trig;
    logic       lvl;
    logic       cap_evt;
    logic       cap_take;

    logic [CNT_W-1:0] cap_q;
    logic             flag_q;

    assign src = ecap_src_e'(src_sel);
    assign pol = ecap_edge_e'(edge_rise);
    assign raw_trig = (src == SRC_CMP) ? trig_cmp : trig_pin;

    ecap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_trig),
        .dout (sync_trig)
    );

    ecap_filter #(.WINDOW(FILT_LEN)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .en    (filt_en),
        .din   (sync_trig),
        .level (lvl)
    );

    ecap_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (lvl),
        .pol   (pol),
        .evt   (cap_evt)
    );

    assign cap_take = cap_evt & ~top_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (top_mode) begin
                if (wr_en) cap_q <= wr_data;
            end else if (cap_evt) begin
                cap_q <= count_in;
            end
            flag_q <= ecap_flag_next(flag_q, cap_take, flag_clr);
        end
    end

    assign cap_value = cap_q;
    assign cap_flag  = flag_q;
endmodule

// File: rtl/edge_capture_unit_chk.sv
module edge_capture_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             top_mode,
    input logic             wr_en,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] count_in,
    input logic             flag_clr,
    input logic             cap_evt,
    input logic [CNT_W-1:0] cap_value,
    input logic             cap_flag
);
    // R2
    a_r2_capture_loads: assert property (@(posedge clk) disable iff (rst)
        (!top_mode && cap_evt) |=> (cap_value == $past(count_in)) && cap_flag);

    // R7
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (cap_flag && !flag_clr) |=> cap_flag);

    // R7
    a_r7_flag_clears: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !(cap_evt && !top_mode)) |=> !cap_flag);

    // R10
    a_r10_top_write: assert property (@(posedge clk) disable iff (rst)
        (top_mode && wr_en) |=> cap_value == $past(wr_data));

    // R10
    a_r10_top_hold: assert property (@(posedge clk) disable iff (rst)
        (top_mode && !wr_en) |=> $stable(cap_value));

    // R10
    a_r10_no_flag: assert property (@(posedge clk) disable iff (rst)
        (top_mode && !cap_flag) |=> !cap_flag);

    // R11
    a_r11_wr_ignored: assert property (@(posedge clk) disable iff (rst)
        (!top_mode && !cap_evt) |=> $stable(cap_value));
endmodule

bind edge_capture_unit edge_capture_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .top_mode  (top_mode),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .count_in  (count_in),
    .flag_clr  (flag_clr),
    .cap_evt   (cap_evt),
    .cap_value (cap_value),
    .cap_flag  (cap_flag)
);

// File: tb/edge_capture_unit_bench.sv
module edge_capture_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig_pin = 1'b0, trig_cmp = 1'b0;
    logic        src_sel = 1'b0, edge_rise = 1'b1, filt_en = 1'b0, top_mode = 1'b0;
    logic [15:0] count_in = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        flag_clr = 1'b0;
    logic [15:0] cap_value;
    logic        cap_flag;

    int n_cmp = 0, n_bad = 0, cyc = 0;

    typedef struct {
        int          at;
        logic [15:0] val;
        string       req;
    } exp_t;
    exp_t sb[$];

    edge_capture_unit u_edge_capture_unit (
        .clk(clk), .rst(rst), .trig_pin(trig_pin), .trig_cmp(trig_cmp),
        .src_sel(src_sel), .edge_rise(edge_rise), .filt_en(filt_en),
        .top_mode(top_mode), .count_in(count_in), .wr_en(wr_en),
        .wr_data(wr_data), .flag_clr(flag_clr), .cap_value(cap_value),
        .cap_flag(cap_flag)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] cnt_of(input int c);
        return 16'(c * 613 + 16'hFF00);
    endfunction

    always @(negedge clk) count_in <= cnt_of(cyc);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].at == cyc) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.req, 32'(cap_value), 32'(e.val));
            chk(e.req, 32'(cap_flag), 32'd1);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // driver: change a trigger; optionally expect a capture after lat edges
    task automatic drive(input bit on_cmp, input bit v, input bit cap, input int lat, input string req);
        @(negedge clk);
        if (on_cmp) trig_cmp = v; else trig_pin = v;
        if (cap) sb.push_back('{cyc + lat, cnt_of(cyc + lat - 1), req});
    endtask

    task automatic clear_flag(input string req);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk(req, 32'(cap_flag), 32'd0);
    endtask

    logic [15:0] held;

    initial begin
        fork
            begin
                idle(4);
                rst = 1'b0;
                idle(1);
                chk("R1 value", 32'(cap_value), 32'd0);
                chk("R1 flag", 32'(cap_flag), 32'd0);

                // R2 / R5: rising capture on pin, filter off
                drive(0, 1, 1, 3, "R2 rising pin");
                idle(6);
                held = cap_value;
                drive(0, 0, 0, 0, "");
                idle(6);
                chk("R5 falling ignored in rising mode", 32'(cap_value), 32'(held));
                clear_flag("R7 clear");
                idle(2);
                chk("R7 stays clear", 32'(cap_flag), 32'd0);

                // R5: falling mode
                edge_rise = 1'b0;
                drive(0, 1, 0, 0, "");
                idle(6);
                chk("R5 rising ignored in falling mode", 32'(cap_flag), 32'd0);
                drive(0, 0, 1, 3, "R5 falling pin");
                idle(6);
                clear_flag("R7 clear");

                // R6: comparator source, pin ignored
                edge_rise = 1'b1;
                src_sel = 1'b1;
                idle(3);
                held = cap_value;
                drive(0, 1, 0, 0, "");
                idle(6);
                chk("R6 pin ignored value", 32'(cap_value), 32'(held));
                chk("R6 pin ignored flag", 32'(cap_flag), 32'd0);
                drive(0, 0, 0, 0, "");
                drive(1, 1, 1, 3, "R6 comparator rising");
                idle(6);
                drive(1, 0, 0, 0, "");
                idle(10);
                clear_flag("R7 clear");

                // R3: filtered latency
                filt_en = 1'b1;
                idle(2);
                drive(1, 1, 1, 7, "R3 filtered latency");
                idle(10);
                drive(1, 0, 0, 0, "");
                idle(12);
                clear_flag("R7 clear");

                // R4: 3-cycle spike rejected, 4-cycle pulse accepted
                held = cap_value;
                drive(1, 1, 0, 0, "");
                idle(2);
                drive(1, 0, 0, 0, "");
                idle(12);
                chk("R4 spike value", 32'(cap_value), 32'(held));
                chk("R4 spike flag", 32'(cap_flag), 32'd0);
                drive(1, 1, 1, 7, "R4 four-cycle pulse");
                idle(3);
                drive(1, 0, 0, 0, "");
                idle(14);

                // R9: overwrite while flag set, filter off
                filt_en = 1'b0;
                idle(2);
                chk("R9 flag still set", 32'(cap_flag), 32'd1);
                drive(1, 1, 1, 3, "R9 overwrite with flag set");
                idle(6);
                drive(1, 0, 0, 0, "");
                idle(6);

                // R8: clear and capture on the same edge
                drive(1, 1, 1, 3, "R8 set beats clear");
                idle(1);
                @(negedge clk); flag_clr = 1'b1;
                @(negedge clk); flag_clr = 1'b0;
                idle(4);
                drive(1, 0, 0, 0, "");
                idle(6);
                clear_flag("R7 clear");

                // R10: TOP mode
                top_mode = 1'b1;
                @(negedge clk); wr_en = 1'b1; wr_data = 16'hBEEF;
                @(negedge clk); wr_en = 1'b0;
                chk("R10 write loads", 32'(cap_value), 32'hBEEF);
                drive(1, 1, 0, 0, "");
                idle(8);
                chk("R10 edge ignored value", 32'(cap_value), 32'hBEEF);
                chk("R10 edge ignored flag", 32'(cap_flag), 32'd0);

                // R11: write ignored outside TOP mode
                top_mode = 1'b0;
                idle(2);
                @(negedge clk); wr_en = 1'b1; wr_data = 16'h1234;
                @(negedge clk); wr_en = 1'b0;
                idle(1);
                chk("R11 write ignored", 32'(cap_value), 32'hBEEF);

                idle(4);
                chk("scoreboard drained", 32'(sb.size()), 32'd0);
            end
            begin
                idle(20000);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule